// File: doc/BRIEF.md
# Maskable Calendar Alarm Comparator

This block watches a running BCD calendar: seconds, minutes, hours with an afternoon bit, day of month and weekday. It raises a sticky alarm flag when the calendar reaches a programmed 32-bit alarm word. Each of the four fields can be removed from the comparison on its own. The day field compares either the day of month or the weekday, chosen by a select bit in the alarm word. The comparison happens only on a one-cycle seconds tick, so a match that lasts a whole second is counted once.

Software reaches the block through a small register bus with four word locations: control at address 0, status at 1, alarm word at 2 and clear at 3. Reads are combinational. The alarm word can only be changed through a handshake. Software first clears the enable bit, then waits for a write-allowed status bit, then writes the new word. A write made while that bit is low is dropped. The interrupt line is the alarm flag gated by an interrupt-enable bit.

Top module: `cal_alarm`

## Requirements
- R1: After reset the control register, the alarm word and the alarm flag read as zero, and `irq_o` is low.
- R2: The alarm word uses this layout:
  - seconds in bits 6:0, with mask bit 7;
  - minutes in bits 14:8, with mask bit 15;
  - hours in bits 21:16, with the afternoon bit at 22 and the hours mask at 23;
  - date in bits 29:24, with the weekday select at 30 and the day mask at 31.

  The word reads back at address 2. On a tick with every field unmasked and equal to the current calendar, the flag (status bit 8) sets.
- R3: A set mask bit removes that field from the comparison. With all four masks set, every tick matches.
- R4: When bit 30 is set, bits 27:24 are compared with the current weekday and the date input is ignored.
- R5: When hours are unmasked, alarm bit 22 must equal `cur_pm_i` for a match.
- R6: The flag sets only on a cycle with `tick_i` high and the enable bit (control bit 8) set.
- R7: Once set, the flag stays set whatever the calendar does until software clears it. A clear and a set in the same cycle leave the flag set.
- R8: Writing status with bit 8 at 0 clears the flag. Writing status with bit 8 at 1 leaves it unchanged.
- R9: Writing the clear register (address 3) with bit 8 at 1 clears the flag.
- R10: `irq_o` is high exactly when the flag is set and the interrupt enable (control bit 12) is set.
- R11: The write-allowed bit (status bit 0) is low while the alarm is enabled. It rises on the second clock edge after the enable bit has been cleared.
- R12: A write to the alarm word while write-allowed is low leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Calendar clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle seconds tick |
| cur_sec_i | input | 7 | Current seconds, BCD |
| cur_min_i | input | 7 | Current minutes, BCD |
| cur_hour_i | input | 6 | Current hours, BCD |
| cur_pm_i | input | 1 | Current afternoon indicator |
| cur_date_i | input | 6 | Current day of month, BCD |
| cur_wday_i | input | 3 | Current weekday, 1 to 7 |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The hardest situation to reach from the ports is a flag that has already been set meeting further ticks, clears and rejected word writes. The stimulus produces it in three steps:
- it arms a matching word and sets the flag with one tick;
- it moves the calendar so the word no longer matches and ticks again, to confirm the flag holds;
- it tries a clear that must be ignored before the two clears that must work.

Attempts to change the word while enabled are checked by reading the word back. The write-allowed delay is sampled edge by edge after the enable bit is dropped.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int unsigned REG_AW   = 2;
  localparam int unsigned BIT_EN   = 8;
  localparam int unsigned BIT_IE   = 12;
  localparam int unsigned BIT_WAF  = 0;
  localparam int unsigned BIT_FLAG = 8;

  typedef enum logic [REG_AW-1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_WORD = 2'd2,
    REG_CLR  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       day_msk;
    logic       wd_sel;
    logic [5:0] date;
    logic       hr_msk;
    logic       pm;
    logic [5:0] hr;
    logic       min_msk;
    logic [6:0] min;
    logic       sec_msk;
    logic [6:0] sec;
  } alarm_word_t;
endpackage

// File: rtl/cal_alarm_ctrl.sv
module cal_alarm_ctrl #(
  parameter int unsigned WAF_DLY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic en_d_i,
  input  logic ie_d_i,
  output logic en_o,
  output logic ie_o,
  output logic waf_o
);
  localparam int unsigned CNT_W = $clog2(WAF_DLY + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WAF_DLY);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o <= 1'b0;
      ie_o <= 1'b0;
    end else if (wr_i) begin
      en_o <= en_d_i;
      ie_o <= ie_d_i;
    end
  end

  // settle counter restarts whenever the alarm is live
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (en_o)            cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign waf_o = !en_o && (cnt_q == CNT_MAX);
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
#(
  parameter int unsigned NF = 4
) (
  input  alarm_word_t word_i,
  input  logic [6:0]  cur_sec_i,
  input  logic [6:0]  cur_min_i,
  input  logic [5:0]  cur_hour_i,
  input  logic        cur_pm_i,
  input  logic [5:0]  cur_date_i,
  input  logic [2:0]  cur_wday_i,
  output logic        match_o
);
  logic [6:0]    a_val [NF];
  logic [6:0]    c_val [NF];
  logic [NF-1:0] msk;
  logic [NF-1:0] hit;

  always_comb begin
    a_val[0] = word_i.sec;
    c_val[0] = cur_sec_i;
    msk[0]   = word_i.sec_msk;
    a_val[1] = word_i.min;
    c_val[1] = cur_min_i;
    msk[1]   = word_i.min_msk;
    a_val[2] = {word_i.pm, word_i.hr};
    c_val[2] = {cur_pm_i, cur_hour_i};
    msk[2]   = word_i.hr_msk;
    a_val[3] = word_i.wd_sel ? {3'b000, word_i.date[3:0]} : {1'b0, word_i.date};
    c_val[3] = word_i.wd_sel ? {4'b0000, cur_wday_i}     : {1'b0, cur_date_i};
    msk[3]   = word_i.day_msk;
  end

  for (genvar i = 0; i < NF; i++) begin : g_fld
    assign hit[i] = msk[i] || (a_val[i] == c_val[i]);
  end

  assign match_o = &hit;
endmodule

// File: rtl/cal_alarm_flag.sv
module cal_alarm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set wins so no event is lost to a racing clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
  import cal_alarm_pkg::*;
#(
  parameter int unsigned WAF_DLY = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic [6:0]  cur_sec_i,
  input  logic [6:0]  cur_min_i,
  input  logic [5:0]  cur_hour_i,
  input  logic        cur_pm_i,
  input  logic [5:0]  cur_date_i,
  input  logic [2:0]  cur_wday_i,
  input  logic        wr_en_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  reg_sel_e    sel;
  alarm_word_t word_q;
  logic en_q, ie_q, waf, flag_q, match, clr_req;

  assign sel = reg_sel_e'(addr_i);

  cal_alarm_ctrl #(.WAF_DLY(WAF_DLY)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_en_i && (sel == REG_CTRL)),
    .en_d_i (wdata_i[BIT_EN]),
    .ie_d_i (wdata_i[BIT_IE]),
    .en_o   (en_q),
    .ie_o   (ie_q),
    .waf_o  (waf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 word_q <= '0;
    else if (wr_en_i && (sel == REG_WORD) && waf) word_q <= alarm_word_t'(wdata_i);
  end

  cal_alarm_match #(.NF(4)) u_match (
    .word_i     (word_q),
    .cur_sec_i  (cur_sec_i),
    .cur_min_i  (cur_min_i),
    .cur_hour_i (cur_hour_i),
    .cur_pm_i   (cur_pm_i),
    .cur_date_i (cur_date_i),
    .cur_wday_i (cur_wday_i),
    .match_o    (match)
  );

  assign clr_req = wr_en_i && (((sel == REG_STAT) && !wdata_i[BIT_FLAG]) ||
                               ((sel == REG_CLR)  &&  wdata_i[BIT_FLAG]));

  cal_alarm_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (tick_i && en_q && match),
    .clr_i  (clr_req),
    .flag_o (flag_q)
  );

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      REG_CTRL: begin
        rdata_o[BIT_EN] = en_q;
        rdata_o[BIT_IE] = ie_q;
      end
      REG_STAT: begin
        rdata_o[BIT_WAF]  = waf;
        rdata_o[BIT_FLAG] = flag_q;
      end
      REG_WORD: rdata_o = word_q;
      REG_CLR:  rdata_o = '0;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = flag_q && ie_q;
endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick_i,
  input logic        wr_en_i,
  input logic [1:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic        irq_o,
  input logic        en_q,
  input logic        ie_q,
  input logic        waf,
  input logic        flag_q,
  input logic [31:0] word_q
);
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ie_q && flag_q)); // R10

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !(wr_en_i && (((addr_i == 2'd1) && !wdata_i[8]) || ((addr_i == 2'd3) && wdata_i[8]))))
    |=> flag_q); // R7

  AST_NO_SET_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !tick_i) |=> !flag_q); // R6

  AST_NO_SET_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !en_q) |=> !flag_q); // R6

  AST_WAF_LOW_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |-> !waf); // R11

  AST_WORD_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !waf |=> $stable(word_q)); // R12
endmodule

bind cal_alarm cal_alarm_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .irq_o   (irq_o),
  .en_q    (en_q),
  .ie_q    (ie_q),
  .waf     (waf),
  .flag_q  (flag_q),
  .word_q  (word_q)
);

// File: tb/cal_alarm_bench.sv
`timescale 1ns/1ps
module cal_alarm_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [6:0]  c_sec = '0, c_min = '0;
  logic [5:0]  c_hr = '0, c_date = '0;
  logic        c_pm = 1'b0;
  logic [2:0]  c_wd = '0;
  logic        wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [31:0] EN = 32'h100;
  localparam logic [31:0] IE = 32'h1000;

  always #2 clk = ~clk;

  cal_alarm u_cal_alarm (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .cur_sec_i(c_sec), .cur_min_i(c_min), .cur_hour_i(c_hr), .cur_pm_i(c_pm),
    .cur_date_i(c_date), .cur_wday_i(c_wd),
    .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // word, sec, min, hr, pm, date, wday, expected irq
  typedef struct packed {
    logic [31:0] w;
    logic [6:0]  s;
    logic [6:0]  m;
    logic [5:0]  h;
    logic        p;
    logic [5:0]  d;
    logic [2:0]  wd;
    logic        e;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h15123456, 7'h56, 7'h34, 6'h12, 1'b0, 6'h15, 3'd2, 1'b1}, // R2 exact
    '{32'h15123456, 7'h57, 7'h34, 6'h12, 1'b0, 6'h15, 3'd2, 1'b0}, // R2 sec off
    '{32'h151234D6, 7'h07, 7'h34, 6'h12, 1'b0, 6'h15, 3'd2, 1'b1}, // R3 sec masked
    '{32'h95123456, 7'h56, 7'h34, 6'h12, 1'b0, 6'h20, 3'd2, 1'b1}, // R3 day masked
    '{32'h43123456, 7'h56, 7'h34, 6'h12, 1'b0, 6'h28, 3'd3, 1'b1}, // R4 weekday hit
    '{32'h43123456, 7'h56, 7'h34, 6'h12, 1'b0, 6'h03, 3'd4, 1'b0}, // R4 weekday miss
    '{32'h15123456, 7'h56, 7'h34, 6'h13, 1'b0, 6'h15, 3'd2, 1'b0}, // R2 hour off
    '{32'h9592B4D6, 7'h01, 7'h02, 6'h03, 1'b1, 6'h04, 3'd5, 1'b1}, // R3 all masked
    '{32'h15523456, 7'h56, 7'h34, 6'h12, 1'b0, 6'h15, 3'd2, 1'b0}, // R5 pm mismatch
    '{32'h1512B456, 7'h56, 7'h00, 6'h13, 1'b0, 6'h15, 3'd2, 1'b0}  // R3 min masked, hour off
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic load_word(input logic [31:0] w);
    bus_wr(2'd0, 32'h0);
    repeat (3) @(negedge clk);
    bus_wr(2'd2, w);
  endtask

  task automatic set_cur(input vec_t v);
    c_sec = v.s; c_min = v.m; c_hr = v.h; c_pm = v.p; c_date = v.d; c_wd = v.wd;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    bus_rd(2'd0, r); chk("R1 ctrl", r, 32'h0);
    bus_rd(2'd1, r); chk("R1 flag", {31'b0, r[8]}, 32'h0);
    bus_rd(2'd2, r); chk("R1 word", r, 32'h0);

    for (int i = 0; i < NV; i++) begin
      load_word(VECS[i].w);
      bus_rd(2'd2, r); chk("R2 readback", r, VECS[i].w);
      bus_wr(2'd0, EN | IE);
      bus_wr(2'd1, 32'h0);
      set_cur(VECS[i]);
      pulse_tick();
      chk($sformatf("R2/R3/R4/R5 vec%0d irq", i), {31'b0, irq}, {31'b0, VECS[i].e});
    end

    // R11 write-allowed timing
    bus_wr(2'd0, EN);
    bus_rd(2'd1, r); chk("R11 waf low enabled", {31'b0, r[0]}, 32'h0);
    bus_wr(2'd0, 32'h0);
    bus_rd(2'd1, r); chk("R11 waf edge0", {31'b0, r[0]}, 32'h0);
    @(negedge clk);
    bus_rd(2'd1, r); chk("R11 waf edge1", {31'b0, r[0]}, 32'h0);
    @(negedge clk);
    bus_rd(2'd1, r); chk("R11 waf edge2", {31'b0, r[0]}, 32'h1);

    // R12 locked word write
    load_word(32'h15123456);
    bus_wr(2'd0, EN | IE);
    bus_wr(2'd2, 32'hDEADBEEF);
    bus_rd(2'd2, r); chk("R12 word held", r, 32'h15123456);

    // R6 no tick, then tick with enable off
    bus_wr(2'd1, 32'h0);
    set_cur(VECS[0]);
    repeat (5) @(negedge clk);
    bus_rd(2'd1, r); chk("R6 no tick", {31'b0, r[8]}, 32'h0);
    bus_wr(2'd0, IE);
    pulse_tick();
    bus_rd(2'd1, r); chk("R6 disabled", {31'b0, r[8]}, 32'h0);

    // R7 sticky
    bus_wr(2'd0, EN | IE);
    pulse_tick();
    chk("R7 set", {31'b0, irq}, 32'h1);
    c_sec = 7'h11;
    pulse_tick();
    repeat (3) @(negedge clk);
    bus_rd(2'd1, r); chk("R7 sticky", {31'b0, r[8]}, 32'h1);

    // R8 clear semantics
    bus_wr(2'd1, 32'h100);
    bus_rd(2'd1, r); chk("R8 write one ignored", {31'b0, r[8]}, 32'h1);
    bus_wr(2'd1, 32'h0);
    bus_rd(2'd1, r); chk("R8 write zero clears", {31'b0, r[8]}, 32'h0);

    // R9 clear register
    c_sec = 7'h56;
    pulse_tick();
    bus_rd(2'd1, r); chk("R9 reset flag", {31'b0, r[8]}, 32'h1);
    bus_wr(2'd3, 32'h100);
    bus_rd(2'd1, r); chk("R9 clear reg", {31'b0, r[8]}, 32'h0);

    // R10 interrupt gating
    bus_wr(2'd0, EN);
    pulse_tick();
    bus_rd(2'd1, r); chk("R10 flag", {31'b0, r[8]}, 32'h1);
    chk("R10 irq masked", {31'b0, irq}, 32'h0);
    bus_wr(2'd0, EN | IE);
    chk("R10 irq unmasked", {31'b0, irq}, 32'h1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule